// File: doc/BRIEF.md
# Clock Control Register Bank with Enable Divider Chain

This block holds 28 words of 32-bit clock configuration behind a word-wide register port. It produces three clock-enable strobes from a single fast clock: one for the core domain, one for the bus domain and one for the peripheral domain. Two single-cycle input pulses stand in for the two possible references, a crystal tick and a main-PLL tick. The bypass bit of the control word (register index 2) selects which of them feeds the chain.

The chain has four stages. An optional thinning stage keeps three of every four source pulses. A core down-counter divides by one plus its field. A bus down-counter divides the core enable by one plus its field. A fixed stage halves the bus enable to give the peripheral enable. The other registers are storage only: they can be written and read back, and they have no other effect.

The request side has no back-pressure and is always ready. A request is a single cycle of `req_valid`. Exactly one cycle later, `rsp_valid` rises for one cycle together with `rsp_rdata` and `rsp_err`.

Top module: `clk_ctrl_unit`

## Requirements
- R1: After reset the registers read as follows: index 0 = 0x800B2C01, index 1 = 0x84002800, index 2 = 0x50032000, indices 6..9 = 0x01010101, index 25 = 0x43000000, and indices 10..21 and 26..27 = 0.
- R2: A word access (`req_size` = 2'b10, `req_addr[1:0]` = 0) at a byte offset below 0x70 selects register `req_addr[6:2]`. A write stores `req_wdata`. A read returns the stored word on `rsp_rdata` one cycle after the request, with `rsp_err` low.
- R3: An access at an offset of 0x70 or above returns zero data and raises `rsp_err` for one cycle. If it is a write, it changes no register. This includes offsets that alias low index bits, such as 0x80.
- R4: An access with `req_size` other than 2'b10, or with `req_addr[1:0]` nonzero, is rejected. It raises `rsp_err`, returns zero data and changes no register.
- R5: Bit 22 of the control word set selects `xtal_pulse` as the source. Cleared, it selects `pll_pulse`. Pulses on the unselected input have no effect.
- R6: When bit 13 of the control word is set, every fourth selected source pulse is dropped. The count starts from the first pulse after the bit is set or after reset. When bit 13 is clear, all pulses pass.
- R7: The core divider field is bits [31:30] = N. `core_en` pulses once per N+1 kept source pulses, one cycle after the kept pulse. The first kept pulse after reset fires it.
- R8: The bus divider field is bits [29:28] = M. `bus_en` pulses once per M+1 `core_en` pulses, one cycle after that `core_en`. The first one after reset fires it.
- R9: `per_en` pulses one cycle after every second `bus_en`, starting with the second `bus_en` after reset.
- R10: A new value of either divider field is used only when that divider next reaches terminal count. The divide already in progress finishes with the old value.
- R11: `usb_div` always shows bits [21:16] of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_pulse | input | 1 | Crystal reference tick |
| pll_pulse | input | 1 | Main PLL reference tick |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the register window |
| req_size | input | 2 | Access size, 2'b10 = 32-bit word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 32 | Read data, zero on error |
| rsp_err | output | 1 | Access rejected |
| core_en | output | 1 | Core domain clock enable |
| bus_en | output | 1 | Bus domain clock enable |
| per_en | output | 1 | Peripheral domain clock enable |
| usb_div | output | 6 | Decoded USB divider field |

## Verification
The hardest situation to reach is a divider field rewritten while a count is already in progress. The old divide has to finish before the new one applies, and this only shows up if the counter sits at a known nonzero value when the write lands. The stimulus reaches that state from reset with a counted number of source pulses under a known divide. It then rewrites the field and counts enables over the following pulses. A long random phase follows. It mixes control writes, both pulse sources and stray accesses, and a per-cycle reference model is compared on every clock.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int unsigned NREG    = 28;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned IDX_W   = $clog2(NREG);
  localparam int unsigned CTL_IDX = 2;
  localparam int unsigned CDIV_W  = 2;
  localparam int unsigned BDIV_W  = 2;
  localparam int unsigned USB_W   = 6;
  localparam int unsigned CDIV_LSB = 30;
  localparam int unsigned BDIV_LSB = 28;
  localparam int unsigned BYP_BIT  = 22;
  localparam int unsigned USB_LSB  = 16;
  localparam int unsigned SRC_BIT  = 13;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef struct packed {
    logic [CDIV_W-1:0] core_div;
    logic [BDIV_W-1:0] bus_div;
    logic              bypass;
    logic [USB_W-1:0]  usb_div;
    logic              thin_sel;
  } ctl_fields_t;

  function automatic logic [DATA_W-1:0] reset_word(input int unsigned idx);
    logic [DATA_W-1:0] v;
    case (idx)
      0:  v = 32'h800B2C01;
      1:  v = 32'h84002800;
      2:  v = 32'h50032000;
      3:  v = 32'h028A0100;
      4:  v = 32'h04008100;
      5:  v = 32'h00000438;
      6, 7, 8, 9: v = 32'h01010101;
      22: v = 32'h00A00000;
      23, 24: v = 32'h0000A030;
      25: v = 32'h43000000;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
#(
  parameter int unsigned N_WORDS = NREG,
  parameter int unsigned AW      = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output ctl_fields_t       ctl
);
  localparam int unsigned IW = $clog2(N_WORDS);
  localparam logic [AW-1:0] WIN_END = AW'(N_WORDS * 4);

  logic [N_WORDS-1:0][DATA_W-1:0] regs;
  logic [IW-1:0]     idx;
  logic              in_win, aligned, hit;
  logic [DATA_W-1:0] rd_word;

  assign idx     = req_addr[IW+1:2];
  assign in_win  = req_addr < WIN_END;
  assign aligned = (req_size == SIZE_WORD) && (req_addr[1:0] == 2'b00);
  assign hit     = req_valid && in_win && aligned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N_WORDS); i++) regs[i] <= reset_word(i);
    end else if (hit && req_write) begin
      regs[idx] <= req_wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < int'(N_WORDS); i++)
      if (idx == IW'(i)) rd_word = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !hit;
      rsp_rdata <= (hit && !req_write) ? rd_word : '0;
    end
  end

  assign ctl.core_div = regs[CTL_IDX][CDIV_LSB +: CDIV_W];
  assign ctl.bus_div  = regs[CTL_IDX][BDIV_LSB +: BDIV_W];
  assign ctl.bypass   = regs[CTL_IDX][BYP_BIT];
  assign ctl.usb_div  = regs[CTL_IDX][USB_LSB +: USB_W];
  assign ctl.thin_sel = regs[CTL_IDX][SRC_BIT];

  // R3
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));
  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  // R4
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != SIZE_WORD) |=> rsp_err);
endmodule

// File: rtl/clkctl_thin.sv
module clkctl_thin (
  input  logic clk,
  input  logic rst_n,
  input  logic thin_on,
  input  logic pulse_in,
  output logic pulse_out
);
  logic [1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase <= 2'd0;
    else if (!thin_on) phase <= 2'd0;
    else if (pulse_in) phase <= phase + 2'd1;
  end

  assign pulse_out = pulse_in && !(thin_on && phase == 2'd3);

  // R6
  thin_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!thin_on) |=> (phase == 2'd0));
endmodule

// File: rtl/clkctl_divider.sv
module clkctl_divider #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_in,
  input  logic [W-1:0] div_val,
  output logic         tick_out
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      tick_out <= 1'b0;
    end else if (tick_in) begin
      if (cnt == '0) begin
        cnt      <= div_val;
        tick_out <= 1'b1;
      end else begin
        cnt      <= cnt - 1'b1;
        tick_out <= 1'b0;
      end
    end else begin
      tick_out <= 1'b0;
    end
  end

  // R7
  div_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> $past(tick_in));
  // R10
  div_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> (cnt == $past(div_val)));
endmodule

// File: rtl/clk_ctrl_unit.sv
module clk_ctrl_unit
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_pulse,
  input  logic              pll_pulse,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              core_en,
  output logic              bus_en,
  output logic              per_en,
  output logic [USB_W-1:0]  usb_div
);
  ctl_fields_t ctl;
  logic src_pulse, kept_pulse, half;

  clkctl_regbank #(.N_WORDS(NREG), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ctl(ctl)
  );

  assign src_pulse = ctl.bypass ? xtal_pulse : pll_pulse;

  clkctl_thin u_thin (
    .clk(clk), .rst_n(rst_n), .thin_on(ctl.thin_sel),
    .pulse_in(src_pulse), .pulse_out(kept_pulse)
  );

  clkctl_divider #(.W(CDIV_W)) u_core_div (
    .clk(clk), .rst_n(rst_n), .tick_in(kept_pulse),
    .div_val(ctl.core_div), .tick_out(core_en)
  );

  clkctl_divider #(.W(BDIV_W)) u_bus_div (
    .clk(clk), .rst_n(rst_n), .tick_in(core_en),
    .div_val(ctl.bus_div), .tick_out(bus_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half   <= 1'b0;
      per_en <= 1'b0;
    end else begin
      if (bus_en) half <= ~half;
      per_en <= bus_en && half;
    end
  end

  assign usb_div = ctl.usb_div;

  // R9
  per_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |-> $past(bus_en));
  // R9
  per_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |=> !per_en);
  // R8
  bus_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> $past(core_en));
endmodule

// File: tb/clk_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
module clk_ctrl_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_pulse = 0, pll_pulse = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = 2'b10;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, core_en, bus_en, per_en;
  logic [31:0] rsp_rdata;
  logic [5:0] usb_div;

  int total = 0, bad = 0;
  bit done = 0, cmp_on = 0;
  int n_core = 0, n_bus = 0, n_per = 0;

  always #4 clk = ~clk;

  clk_ctrl_unit dut_i (
    .clk(clk), .rst_n(rst_n), .xtal_pulse(xtal_pulse), .pll_pulse(pll_pulse),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .core_en(core_en), .bus_en(bus_en), .per_en(per_en), .usb_div(usb_div)
  );

  // behavioural reference model
  logic [31:0] m_reg [28];
  int m_phase, m_ccnt, m_bcnt;
  bit m_half, m_core, m_bus, m_per, m_rv, m_err;
  logic [31:0] m_rd;

  function automatic logic [31:0] rv(int i);
    if (i == 0) return 32'h800B2C01;
    if (i == 1) return 32'h84002800;
    if (i == 2) return 32'h50032000;
    if (i == 3) return 32'h028A0100;
    if (i == 4) return 32'h04008100;
    if (i == 5) return 32'h00000438;
    if (i >= 6 && i <= 9) return 32'h01010101;
    if (i == 22) return 32'h00A00000;
    if (i == 23 || i == 24) return 32'h0000A030;
    if (i == 25) return 32'h43000000;
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 28; i++) m_reg[i] <= rv(i);
      m_phase <= 0; m_ccnt <= 0; m_bcnt <= 0;
      m_half <= 0; m_core <= 0; m_bus <= 0; m_per <= 0;
      m_rv <= 0; m_err <= 0; m_rd <= 0;
    end else begin
      logic [31:0] c;
      bit src, kept, ok;
      int a;
      c = m_reg[2];
      src = c[22] ? xtal_pulse : pll_pulse;
      kept = src;
      if (!c[13]) m_phase <= 0;
      else if (src) begin
        if (m_phase == 3) kept = 0;
        m_phase <= (m_phase + 1) % 4;
      end
      if (kept) begin
        if (m_ccnt == 0) begin m_core <= 1; m_ccnt <= int'(c[31:30]); end
        else begin m_core <= 0; m_ccnt <= m_ccnt - 1; end
      end else m_core <= 0;
      if (m_core) begin
        if (m_bcnt == 0) begin m_bus <= 1; m_bcnt <= int'(c[29:28]); end
        else begin m_bus <= 0; m_bcnt <= m_bcnt - 1; end
      end else m_bus <= 0;
      if (m_bus) m_half <= !m_half;
      m_per <= m_bus && m_half;
      a = int'(req_addr);
      ok = req_valid && a < 112 && req_size == 2'b10 && (a % 4) == 0;
      m_rv <= req_valid;
      m_err <= req_valid && !ok;
      m_rd <= (ok && !req_write) ? m_reg[a / 4] : 32'h0;
      if (ok && req_write) m_reg[a / 4] <= req_wdata;
    end
  end

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (core_en) n_core++;
      if (bus_en) n_bus++;
      if (per_en) n_per++;
    end
    if (rst_n && cmp_on) begin
      chk(rsp_valid == m_rv, "R2 rsp_valid", 32'(rsp_valid), 32'(m_rv));
      chk(rsp_rdata == m_rd, "R2 rsp_rdata", rsp_rdata, m_rd);
      chk(rsp_err == m_err, "R3 R4 rsp_err", 32'(rsp_err), 32'(m_err));
      chk(core_en == m_core, "R7 R10 core_en", 32'(core_en), 32'(m_core));
      chk(bus_en == m_bus, "R8 bus_en", 32'(bus_en), 32'(m_bus));
      chk(per_en == m_per, "R9 per_en", 32'(per_en), 32'(m_per));
      chk(usb_div == m_reg[2][21:16], "R11 usb_div", 32'(usb_div), 32'(m_reg[2][21:16]));
    end
  end

  task automatic access(input bit wr, input logic [11:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output bit er);
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic send(input int n, input bit use_x);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; xtal_pulse = use_x; pll_pulse = !use_x;
      @(posedge clk); #1; xtal_pulse = 0; pll_pulse = 0;
    end
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 0;
    repeat (2) @(posedge clk); #1; rst_n = 1;
  endtask

  task automatic clr_counts();
    n_core = 0; n_bus = 0; n_per = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit e;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    cmp_on = 1;
    // R1 reset values
    access(0, 12'h000, 2'b10, 0, d, e); chk(d == 32'h800B2C01 && !e, "R1 reg0", d, 32'h800B2C01);
    access(0, 12'h004, 2'b10, 0, d, e); chk(d == 32'h84002800, "R1 reg1", d, 32'h84002800);
    access(0, 12'h008, 2'b10, 0, d, e); chk(d == 32'h50032000, "R1 reg2", d, 32'h50032000);
    access(0, 12'h018, 2'b10, 0, d, e); chk(d == 32'h01010101, "R1 reg6", d, 32'h01010101);
    access(0, 12'h064, 2'b10, 0, d, e); chk(d == 32'h43000000, "R1 reg25", d, 32'h43000000);
    access(0, 12'h06C, 2'b10, 0, d, e); chk(d == 32'h0, "R1 reg27", d, 32'h0);
    chk(usb_div == 6'h03, "R11 reset usb", 32'(usb_div), 32'h3);
    // R2 write/readback
    access(1, 12'h030, 2'b10, 32'hA5A5_1234, d, e); chk(!e, "R2 write ok", 32'(e), 0);
    access(0, 12'h030, 2'b10, 0, d, e); chk(d == 32'hA5A5_1234, "R2 readback", d, 32'hA5A51234);
    // R3 out of window
    access(1, 12'h070, 2'b10, 32'hFFFF_FFFF, d, e); chk(e, "R3 err at 0x70", 32'(e), 1);
    access(0, 12'h070, 2'b10, 0, d, e); chk(e && d == 0, "R3 read 0x70", d, 0);
    access(1, 12'h080, 2'b10, 32'h1111_1111, d, e); chk(e, "R3 err at 0x80", 32'(e), 1);
    access(0, 12'h000, 2'b10, 0, d, e); chk(d == 32'h800B2C01, "R3 no alias write", d, 32'h800B2C01);
    // R4 bad size / misaligned
    access(1, 12'h00C, 2'b01, 32'h0, d, e); chk(e, "R4 narrow err", 32'(e), 1);
    access(1, 12'h00E, 2'b10, 32'h0, d, e); chk(e, "R4 misaligned err", 32'(e), 1);
    access(0, 12'h00C, 2'b10, 0, d, e); chk(d == 32'h028A0100, "R4 reg3 intact", d, 32'h028A0100);

    // R6 thinning: fresh reset, thin on, divides 0
    do_reset();
    access(1, 12'h008, 2'b10, 32'h0000_2000, d, e);
    clr_counts(); send(8, 0);
    chk(n_core == 6, "R6 kept 6 of 8", n_core, 6);
    chk(n_bus == 6, "R8 bus div0", n_bus, 6);
    chk(n_per == 3, "R9 per halves", n_per, 3);
    // R5 bypass
    access(1, 12'h008, 2'b10, 32'h0040_0000, d, e);
    clr_counts(); send(4, 0);
    chk(n_core == 0, "R5 pll ignored in bypass", n_core, 0);
    clr_counts(); send(4, 1);
    chk(n_core == 4, "R5 xtal used in bypass", n_core, 4);
    // R7 R10 core divide and deferred update
    access(1, 12'h008, 2'b10, 32'h8000_0000, d, e);
    clr_counts(); send(4, 0);
    chk(n_core == 2, "R7 div3 first fires", n_core, 2);
    access(1, 12'h008, 2'b10, 32'h0000_0000, d, e);
    clr_counts(); send(3, 0);
    chk(n_core == 1, "R10 old divide completes", n_core, 1);
    clr_counts(); send(3, 0);
    chk(n_core == 3, "R10 new divide applied", n_core, 3);
    // R8 bus divide 4
    access(1, 12'h008, 2'b10, 32'h3000_0000, d, e);
    clr_counts(); send(9, 0);
    chk(n_bus == 3, "R8 bus div4", n_bus, 3);

    // random phase compared to model
    for (int k = 0; k < 4000; k++) begin
      @(posedge clk); #1;
      xtal_pulse = ($urandom % 3) == 0;
      pll_pulse = ($urandom % 2) == 0;
      req_valid = ($urandom % 6) == 0;
      req_write = $urandom % 2;
      case ($urandom % 4)
        0: req_addr = 12'h008;
        1: req_addr = 12'($urandom % 128);
        2: req_addr = 12'(($urandom % 28) * 4);
        default: req_addr = 12'($urandom);
      endcase
      req_size = ($urandom % 5 == 0) ? 2'($urandom) : 2'b10;
      req_wdata = $urandom;
    end
    @(posedge clk); #1;
    req_valid = 0; xtal_pulse = 0; pll_pulse = 0;
    repeat (5) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule